// File: doc/BRIEF.md
# Pulse-Width Label Demodulator

This receiver block pulls a slow binary label out of a fast frame signal. The transmitter marks a label 1 by shifting the frame's bit timing, which shortens some high pulses. The block samples the incoming frame signal with a fast local clock, passing it through a synchronizer first. It times every high run in clock counts and flags each run that is shorter than the nominal unmodulated bit period.

The flags are then grouped into label-bit windows of a configured number of clock cycles. A window that holds at least a minimum number of short pulses (two by default) is read as 1. Any other window is read as 0. Each label frame opens with a modulated sync bit, followed by a configured number of payload bits.

While hunting, the first short pulse opens a candidate sync window. If that window qualifies, the payload windows follow back to back, and each one yields one output bit with a valid strobe. The sync bit itself is never output. After the last payload bit the block pulses frame-done and goes back to hunting. Clock and data recovery of the frame itself is handled elsewhere.

Top module: `lbl_demod`

## Requirements
- R1: The frame input passes through a two-flop synchronizer. A high run's length is the number of consecutive high synchronized samples, counted from the rising edge to the falling edge.
- R2: A high run is short when its length is strictly less than `cfg_nominal`. A run of exactly `cfg_nominal` samples or more is not short.
- R3: The run counter saturates at 2^RUN_W-1. A saturated run is never short, however long it lasts.
- R4: While hunting, the first short pulse opens a sync window of `cfg_window` cycles. The sync is accepted only if the window holds at least MIN_PULSES short pulses (default 2). Otherwise the block returns to hunting and outputs nothing.
- R5: After an accepted sync, consecutive windows of `cfg_window` cycles each decide one payload bit. The bit is 1 when the window holds at least MIN_PULSES short pulses and 0 otherwise.
- R6: The sync bit is never output. Each accepted frame yields exactly `cfg_len` bits, in the order they were sent.
- R7: `bit_valid` is a single-cycle pulse in the cycle after a payload window closes, and `bit_out` holds the decided bit in that cycle. Two strobes are never adjacent.
- R8: `frame_done` pulses for one cycle together with the final `bit_valid` of a frame. The block is then hunting again and can accept the next frame.
- R9: An unmodulated frame signal, or one after reset, produces no `bit_valid` and no `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_in | input | 1 | Received frame signal, asynchronous to clk |
| cfg_nominal | input | RUN_W | Nominal unmodulated high-run length in clock counts |
| cfg_window | input | WIN_W | Label-bit window length in clock cycles (at least 2) |
| cfg_len | input | LEN_W | Payload bits per label frame (at least 1) |
| bit_out | output | 1 | Demodulated payload bit |
| bit_valid | output | 1 | Strobe marking `bit_out` valid |
| frame_done | output | 1 | Pulse with the last payload bit of a frame |

## Verification
The in-RTL assertions check the following on every cycle:
- short-pulse flags are never adjacent;
- a saturated run never flags;
- the first cycle after a sync window carries no strobe;
- strobes are isolated;
- frame-done always rides on a strobe and leaves the block hunting.

Other behaviours can only be shown by the bench scenarios: correct bit values, exact bit counts, the strict threshold at `cfg_nominal`, rejection of lone pulses and of wrapped long runs, and clean recovery between back-to-back frames. The bench covers them with an exhaustive sweep of every 4-bit payload, 10-bit alternating and constant patterns, single-bit frames and threshold-edge pulse lengths.

// File: rtl/lbl_pkg.sv
package lbl_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } dmd_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_info_t;

    typedef struct packed {
        logic valid;
        logic value;
        logic last;
    } bit_evt_t;

    function automatic logic meets_min(input int unsigned count, input int unsigned min_n);
        return count >= min_n;
    endfunction

endpackage

// File: rtl/lbl_edge_sync.sv
module lbl_edge_sync
    import lbl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    output edge_info_t edges
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
            prev <= 1'b0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
            prev <= pipe[STAGES-1];
        end
    end

    assign edges.level = pipe[STAGES-1];
    assign edges.rise  = pipe[STAGES-1] & ~prev;
    assign edges.fall  = ~pipe[STAGES-1] & prev;

endmodule

// File: rtl/lbl_run_meter.sv
module lbl_run_meter
    import lbl_pkg::*;
#(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_info_t       edges,
    input  logic [RUN_W-1:0] nominal,
    output logic             short_pulse
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] run_len;
    logic             saturated;

    assign saturated = (run_len == RUN_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len     <= '0;
            short_pulse <= 1'b0;
        end else begin
            short_pulse <= edges.fall && !saturated && (run_len < nominal);
            if (edges.rise) begin
                run_len <= RUN_W'(1);
            end else if (edges.level && !saturated) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    // R2: a falling edge can never follow another falling edge directly
    a_r2_short_isolated: assert property (@(posedge clk) disable iff (rst)
        short_pulse |=> !short_pulse);

    // R3: a run that reached the counter limit never counts as short
    a_r3_saturated_not_short: assert property (@(posedge clk) disable iff (rst)
        (edges.fall && saturated) |=> !short_pulse);

endmodule

// File: rtl/lbl_frame_fsm.sv
module lbl_frame_fsm
    import lbl_pkg::*;
#(
    parameter int WIN_W      = 10,
    parameter int LEN_W      = 6,
    parameter int PCNT_W     = 4,
    parameter int MIN_PULSES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             short_pulse,
    input  logic [WIN_W-1:0] win_len,
    input  logic [LEN_W-1:0] frame_len,
    output bit_evt_t         evt
);
    localparam logic [PCNT_W-1:0] PCNT_MAX = '1;

    dmd_state_e        state;
    logic [WIN_W-1:0]  wcnt;
    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] pcnt_next;
    logic [LEN_W-1:0]  bidx;
    logic              win_end;
    logic              decided_one;

    assign win_end     = (state != ST_HUNT) &&
                         (({1'b0, wcnt} + 1'b1) == {1'b0, win_len});
    assign pcnt_next   = (short_pulse && pcnt != PCNT_MAX) ? pcnt + 1'b1 : pcnt;
    assign decided_one = meets_min(int'(pcnt_next), MIN_PULSES);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            wcnt  <= '0;
            pcnt  <= '0;
            bidx  <= '0;
            evt   <= '0;
        end else begin
            evt <= '0;
            unique case (state)
                ST_HUNT: begin
                    if (short_pulse) begin
                        state <= ST_SYNC;
                        wcnt  <= WIN_W'(1);
                        pcnt  <= PCNT_W'(1);
                    end
                end
                ST_SYNC, ST_DATA: begin
                    if (win_end) begin
                        wcnt <= '0;
                        pcnt <= '0;
                        if (state == ST_SYNC) begin
                            state <= decided_one ? ST_DATA : ST_HUNT;
                            bidx  <= '0;
                        end else begin
                            evt.valid <= 1'b1;
                            evt.value <= decided_one;
                            if (bidx == frame_len - 1'b1) begin
                                evt.last <= 1'b1;
                                state    <= ST_HUNT;
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                        pcnt <= pcnt_next;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // R6: the cycle after the sync window closes carries no payload strobe
    a_r6_sync_not_emitted: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_SYNC) |-> !evt.valid);

    // R6: the payload index stays inside the frame
    a_r6_index_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> (bidx < frame_len));

    // R7: strobes are isolated single-cycle pulses
    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> !evt.valid);

    // R8: frame end coincides with a strobe and leaves the block hunting
    a_r8_last_with_valid: assert property (@(posedge clk) disable iff (rst)
        evt.last |-> (evt.valid && state == ST_HUNT));

endmodule

// File: rtl/lbl_demod.sv
module lbl_demod
    import lbl_pkg::*;
#(
    parameter int RUN_W       = 8,
    parameter int WIN_W       = 10,
    parameter int LEN_W       = 6,
    parameter int PCNT_W      = 4,
    parameter int MIN_PULSES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_in,
    input  logic [RUN_W-1:0] cfg_nominal,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             bit_out,
    output logic             bit_valid,
    output logic             frame_done
);
    edge_info_t edges;
    logic       short_pulse;
    bit_evt_t   evt;

    lbl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (frame_in),
        .edges (edges)
    );

    lbl_run_meter #(.RUN_W(RUN_W)) u_meter (
        .clk         (clk),
        .rst         (rst),
        .edges       (edges),
        .nominal     (cfg_nominal),
        .short_pulse (short_pulse)
    );

    lbl_frame_fsm #(
        .WIN_W      (WIN_W),
        .LEN_W      (LEN_W),
        .PCNT_W     (PCNT_W),
        .MIN_PULSES (MIN_PULSES)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .short_pulse (short_pulse),
        .win_len     (cfg_window),
        .frame_len   (cfg_len),
        .evt         (evt)
    );

    assign bit_out    = evt.value;
    assign bit_valid  = evt.valid;
    assign frame_done = evt.last;

endmodule

// File: tb/lbl_demod_tb.sv
`timescale 1ns/1ps
module lbl_demod_tb;
    localparam int RUN_W = 8;
    localparam int WIN_W = 10;
    localparam int LEN_W = 6;
    localparam int NOM   = 8;
    localparam int WIN   = 64;
    localparam int GAP   = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_in = 1'b0;
    logic [RUN_W-1:0] cfg_nominal = RUN_W'(NOM);
    logic [WIN_W-1:0] cfg_window  = WIN_W'(WIN);
    logic [LEN_W-1:0] cfg_len     = LEN_W'(4);
    logic bit_out, bit_valid, frame_done;

    always #2.5 clk = ~clk;

    lbl_demod u_dut (
        .clk(clk), .rst(rst), .frame_in(frame_in),
        .cfg_nominal(cfg_nominal), .cfg_window(cfg_window), .cfg_len(cfg_len),
        .bit_out(bit_out), .bit_valid(bit_valid), .frame_done(frame_done)
    );

    // stimulus generator: runs of NOM samples when label is 0, mod_len when 1
    logic lbl_lvl = 1'b0;
    int   mod_len = 6;
    int   rem = 0;
    int   restart_req = 0;
    int   restart_seen = 0;
    logic manual = 1'b0;
    logic man_val = 1'b0;

    always @(negedge clk) begin
        if (manual) begin
            frame_in <= man_val;
        end else if (restart_req != restart_seen) begin
            restart_seen <= restart_req;
            frame_in <= 1'b1;
            rem <= mod_len - 1;
        end else if (rem == 0) begin
            frame_in <= ~frame_in;
            rem <= (lbl_lvl ? mod_len : NOM) - 1;
        end else begin
            rem <= rem - 1;
        end
    end

    // output monitor
    logic [31:0] rx = '0;
    int rx_n = 0, done_n = 0, done_at = 0, dbl_n = 0, orphan_n = 0;
    logic prev_valid = 1'b0;

    always @(negedge clk) begin
        prev_valid <= bit_valid;
        if (!rst) begin
            if (bit_valid) begin
                rx   <= {rx[30:0], bit_out};
                rx_n <= rx_n + 1;
                if (prev_valid) dbl_n <= dbl_n + 1;
            end
            if (frame_done) begin
                done_n  <= done_n + 1;
                done_at <= rx_n + (bit_valid ? 1 : 0);
                if (!bit_valid) orphan_n <= orphan_n + 1;
            end
        end
    end

    int checks = 0, fails = 0, cyc = 0;
    logic ended = 1'b0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            report();
        end
    end

    task automatic send_frame(input logic [15:0] pay, input int len, input bit expect_ok, input string tag);
        int base_n;
        int base_done;
        logic [31:0] mask;
        cfg_len = LEN_W'(len);
        base_n = rx_n;
        base_done = done_n;
        @(posedge clk);
        while (frame_in) @(posedge clk);
        restart_req = restart_req + 1;
        lbl_lvl = 1'b1;
        repeat (WIN) @(posedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            lbl_lvl = pay[i];
            repeat (WIN) @(posedge clk);
        end
        lbl_lvl = 1'b0;
        repeat (GAP) @(posedge clk);
        mask = (32'd1 << len) - 32'd1;
        if (expect_ok) begin
            check(rx_n - base_n == len, {tag, " R6 bit count"}, rx_n - base_n, len);
            check((rx & mask) == ({16'd0, pay} & mask), {tag, " R5 payload"},
                  int'(rx & mask), int'({16'd0, pay} & mask));
            check(done_n - base_done == 1, {tag, " R8 done count"}, done_n - base_done, 1);
            check(done_at - base_n == len, {tag, " R8 done on last bit"}, done_at - base_n, len);
        end else begin
            check(rx_n == base_n, {tag, " no bits"}, rx_n - base_n, 0);
            check(done_n == base_done, {tag, " no done"}, done_n - base_done, 0);
        end
    endtask

    task automatic manual_level(input logic v, input int n);
        man_val = v;
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int base_n;
        repeat (4) @(negedge clk);
        check(bit_valid == 1'b0, "R9 reset valid", int'(bit_valid), 0);
        check(frame_done == 1'b0, "R9 reset done", int'(frame_done), 0);
        check(bit_out == 1'b0, "R9 reset bit", int'(bit_out), 0);
        @(posedge clk);
        rst = 1'b0;

        // R9: idle unmodulated signal yields nothing
        repeat (400) @(posedge clk);
        check(rx_n == 0, "R9 idle bits", rx_n, 0);
        check(done_n == 0, "R9 idle done", done_n, 0);

        // R5 R6: exhaustive 4-bit payload sweep
        for (int p = 0; p < 16; p++) begin
            send_frame(16'(p), 4, 1'b1, "sweep4");
        end

        // R6 R8: 10-bit patterns, back-to-back frames
        send_frame(16'b0101010101, 10, 1'b1, "alt0101");
        send_frame(16'b1010101010, 10, 1'b1, "alt1010");
        send_frame(16'b1111111111, 10, 1'b1, "ones10");
        send_frame(16'b0000000000, 10, 1'b1, "zeros10");

        // R6: single-bit frames
        send_frame(16'd1, 1, 1'b1, "len1 one");
        send_frame(16'd0, 1, 1'b1, "len1 zero");

        // R1 R2: runs one count below the nominal are short
        mod_len = NOM - 1;
        send_frame(16'b1011, 4, 1'b1, "R1 R2 nominal-1");
        // R2: runs equal to the nominal are not short
        mod_len = NOM;
        send_frame(16'b1111, 4, 1'b0, "R2 equal nominal");
        mod_len = 6;

        // R4: isolated short pulses further apart than a window never sync
        cfg_len = LEN_W'(4);
        base_n = rx_n;
        manual = 1'b1;
        manual_level(1'b0, 20);
        manual_level(1'b1, 4);
        manual_level(1'b0, WIN + 40);
        manual_level(1'b1, 4);
        manual_level(1'b0, WIN * 6);
        check(rx_n == base_n, "R4 lone pulses", rx_n - base_n, 0);

        // R3: a run past the counter range must not wrap into a short pulse
        base_n = rx_n;
        manual_level(1'b0, 20);
        manual_level(1'b1, 259);
        manual_level(1'b0, 10);
        manual_level(1'b1, 4);
        manual_level(1'b0, WIN * 7);
        check(rx_n == base_n, "R3 saturated run", rx_n - base_n, 0);
        manual = 1'b0;

        // R8: block still accepts a frame afterwards
        send_frame(16'b0110, 4, 1'b1, "R8 after rejects");

        check(dbl_n == 0, "R7 adjacent strobes", dbl_n, 0);
        check(orphan_n == 0, "R8 done without strobe", orphan_n, 0);
        report();
    end

endmodule